// File: doc/BRIEF.md
# Piecewise-Linear Gaussian Activation Unit

This unit produces the bell-shaped activation of one hidden neuron in a radial-basis network. The exponential is not evaluated. The unit takes the magnitude of a signed fixed-point argument and compares it against four breakpoints. That selects one of five straight-line segments. The result is a single multiply-add: the segment slope times the magnitude, plus the segment intercept. Because only the magnitude is used, the curve is even about zero. The peak of 1.0 sits at an argument of zero.

The slope and intercept pairs sit in a small constant table. Breakpoints and coefficients are written in thousandths in a shared package. At elaboration they are rounded to the nearest code of the chosen fractional width. The upstream distance stage presents one argument with a valid strobe. The result appears with its own valid strobe on the next clock. The result is held until the next accepted argument.

Top module: `gauss_pwl`

## Requirements
- R1: `in_data` and `out_data` are 16-bit two's-complement fixed point with 7 fractional bits, so code 128 means 1.0.
- R2: The output for argument -x equals the output for +x for every x except the most negative code.
- R3: The magnitude m selects segment 0..4 as the number of breakpoint codes {77, 154, 230, 307} that m is greater than or equal to.
- R4: The slope codes for segments 0..4 are -35, -74, -61, -30, -12, and the intercept codes are 128, 151, 136, 80, 36.
- R5: Before clamping, the result is ((k*m + 64) >>> 7) + b, with a full-width signed product and an arithmetic shift.
- R6: A negative result is clamped to 0 and a result above 128 is clamped to 128. Every magnitude of 384 (3.0) or more therefore gives 0.
- R7: The input code -32768 is handled as magnitude 32767, which gives 0.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `out_data` changes only in the cycle after an accepted argument.
- R9: While `rst_n` is low, `out_valid` is 0, and it goes to 0 without waiting for a clock edge.
- R10: For every argument with magnitude up to 4.0, the output is within 0.05 of exp(-x*x/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_valid | input | 1 | Argument strobe |
| in_data | input | 16 | Signed argument, 7 fractional bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 16 | Activation value, 0 to 128 |

## Verification
Two situations are hard to reach. The first is where a breakpoint comparison flips. The second is where rounding of a negative product sits exactly on a half step. Uniform random arguments over the full 16-bit range almost never land on either. The stimulus therefore draws most random values from within plus or minus 4.0. It sweeps every code from -520 to 520 once, and it adds directed arguments one code either side of each breakpoint, both signs, and the most negative code. Random gaps in `in_valid` exercise the hold behaviour. A reset pulse taken while a result is valid shows that the strobe clears without a clock edge.

// File: rtl/gauss_pwl_pkg.sv
package gauss_pwl_pkg;

  localparam int SEG_N = 5;

  // Segment boundaries and line coefficients, in thousandths.
  localparam int MILLI_BP [SEG_N-1] = '{600, 1200, 1800, 2400};
  localparam int MILLI_K  [SEG_N]   = '{-275, -580, -480, -238, -93};
  localparam int MILLI_B  [SEG_N]   = '{1000, 1183, 1063, 628, 280};

  // Round a value given in thousandths to the nearest fixed-point code.
  function automatic int milli_to_fix(input int v, input int frac);
    int scaled;
    if (v >= 0) begin
      scaled = (v * (1 << frac) + 500) / 1000;
    end else begin
      scaled = -((-v * (1 << frac) + 500) / 1000);
    end
    return scaled;
  endfunction

endpackage

// File: rtl/gauss_abs.sv
module gauss_abs #(
  parameter int W = 16
) (
  input  logic [W-1:0] arg,
  output logic [W-1:0] mag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!arg[W-1]) begin
      mag = arg;
    end else if (arg == MOST_NEG) begin
      mag = MOST_POS;
    end else begin
      mag = (~arg) + 1'b1;
    end
  end
endmodule

// File: rtl/gauss_seg_sel.sv
module gauss_seg_sel
  import gauss_pwl_pkg::*;
#(
  parameter int W     = 16,
  parameter int F     = 7,
  parameter int SEG_W = $clog2(SEG_N)
) (
  input  logic [W-1:0]     mag,
  output logic [SEG_W-1:0] seg
);
  logic [SEG_N-2:0] hit;

  for (genvar i = 0; i < SEG_N - 1; i++) begin : g_cmp
    localparam logic [W-1:0] BP_CODE = W'(milli_to_fix(MILLI_BP[i], F));
    assign hit[i] = (mag >= BP_CODE);
  end

  always_comb begin
    seg = '0;
    for (int i = 0; i < SEG_N - 1; i++) begin
      seg = seg + SEG_W'(hit[i]);
    end
  end
endmodule

// File: rtl/gauss_coef_rom.sv
module gauss_coef_rom
  import gauss_pwl_pkg::*;
#(
  parameter int W     = 16,
  parameter int F     = 7,
  parameter int SEG_W = $clog2(SEG_N)
) (
  input  logic [SEG_W-1:0]    addr,
  output logic signed [W-1:0] slope,
  output logic signed [W-1:0] icpt
);
  localparam int DEPTH = 1 << SEG_W;

  logic signed [W-1:0] k_mem [DEPTH];
  logic signed [W-1:0] b_mem [DEPTH];

  // Entries past the last segment repeat it, so every address is defined.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int IDX = (i < SEG_N) ? i : SEG_N - 1;
    assign k_mem[i] = W'(milli_to_fix(MILLI_K[IDX], F));
    assign b_mem[i] = W'(milli_to_fix(MILLI_B[IDX], F));
  end

  assign slope = k_mem[addr];
  assign icpt  = b_mem[addr];
endmodule

// File: rtl/gauss_mac.sv
module gauss_mac #(
  parameter int W = 16,
  parameter int F = 7
) (
  input  logic [W-1:0]        mag,
  input  logic signed [W-1:0] slope,
  input  logic signed [W-1:0] icpt,
  output logic [W-1:0]        result
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (F - 1);
  localparam logic signed [PW-1:0] ONE  = PW'(1) <<< F;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [PW-1:0] sum;

  always_comb begin
    prod   = PW'(slope) * PW'($signed(mag));
    scaled = (prod + HALF) >>> F;
    sum    = scaled + PW'(icpt);
    if (sum < 0) begin
      result = '0;
    end else if (sum > ONE) begin
      result = W'(ONE);
    end else begin
      result = W'(sum);
    end
  end
endmodule

// File: rtl/gauss_pwl.sv
module gauss_pwl
  import gauss_pwl_pkg::*;
#(
  parameter int W = 16,
  parameter int F = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int SEG_W = $clog2(SEG_N);
  localparam logic [W-1:0] ONE_CODE  = W'(1 << F);
  localparam logic signed [W-1:0] TAIL_CODE = W'(3 << F);

  logic [W-1:0]        mag;
  logic [SEG_W-1:0]    seg;
  logic signed [W-1:0] slope;
  logic signed [W-1:0] icpt;
  logic [W-1:0]        act;
  logic                valid_nxt;
  logic [W-1:0]        data_nxt;

  gauss_abs #(.W(W)) u_abs (
    .arg (in_data),
    .mag (mag)
  );

  gauss_seg_sel #(.W(W), .F(F), .SEG_W(SEG_W)) u_sel (
    .mag (mag),
    .seg (seg)
  );

  gauss_coef_rom #(.W(W), .F(F), .SEG_W(SEG_W)) u_rom (
    .addr  (seg),
    .slope (slope),
    .icpt  (icpt)
  );

  gauss_mac #(.W(W), .F(F)) u_mac (
    .mag    (mag),
    .slope  (slope),
    .icpt   (icpt),
    .result (act)
  );

  // Next-state logic, with the data register enabled by in_valid.
  always_comb begin
    valid_nxt = in_valid;
    data_nxt  = out_data;
    if (in_valid) begin
      data_nxt = act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_data  <= data_nxt;
    end
  end

  // R8: the result strobe follows the argument strobe by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R6: the result always lies between 0 and 1.0
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= ONE_CODE));
  // R6: a magnitude of 3.0 or more gives 0
  a_r6_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($signed(in_data) >= TAIL_CODE || $signed(in_data) <= -TAIL_CODE))
    |=> (out_data == '0));
  // R5: a zero argument gives the peak value
  a_r5_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |=> (out_data == ONE_CODE));
endmodule

// File: tb/tb_gauss_pwl.sv
module tb_gauss_pwl;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;

  int checks;
  int failures;
  int cycles;

  gauss_pwl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model taken from R3..R7.
  function automatic int model(input int x);
    int m, s, k, b, p, q, y;
    int kt [5];
    int bt [5];
    kt = '{-35, -74, -61, -30, -12};
    bt = '{128, 151, 136, 80, 36};
    if (x == -32768) m = 32767;
    else if (x < 0) m = -x;
    else m = x;
    s = 0;
    if (m >= 77)  s++;
    if (m >= 154) s++;
    if (m >= 230) s++;
    if (m >= 307) s++;
    k = kt[s];
    b = bt[s];
    p = k * m;
    q = (p + 64) >>> 7;
    y = q + b;
    if (y < 0) y = 0;
    if (y > 128) y = 128;
    return y;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one argument and check the result on the following cycle.
  task automatic apply(input int x, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, "/R8 valid"}, int'(out_valid), 1);
    check(req, int'(out_data), model(x));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int bps [4];
    int last;
    int pend;
    int pend_x;
    checks = 0;
    failures = 0;
    bps = '{77, 154, 230, 307};
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle valid", int'(out_valid), 0);

    // Directed corner cases
    apply(0, "R5 zero");
    check("R1 peak code", int'(out_data), 128);
    for (int i = 0; i < 4; i++) begin
      apply(bps[i] - 1, "R3 below bp");
      apply(bps[i], "R3 at bp");
      apply(-bps[i], "R2 neg at bp");
    end
    apply(38, "R4 seg0");
    apply(120, "R4 seg1");
    apply(200, "R4 seg2");
    apply(260, "R4 seg3");
    apply(350, "R4 seg4");
    apply(384, "R6 tail 3.0");
    check("R6 tail zero", int'(out_data), 0);
    apply(390, "R6 negative clamp");
    apply(32767, "R6 max positive");
    apply(-32768, "R7 most negative");
    check("R7 zero", int'(out_data), 0);

    // Symmetry sweep plus accuracy
    for (int x = -520; x <= 520; x++) begin
      int yp;
      real ideal, err, xr;
      apply(x, "R5 sweep");
      yp = int'(out_data);
      xr = real'(x) / 128.0;
      ideal = $exp(-xr * xr / 2.0);
      err = real'(yp) / 128.0 - ideal;
      if (err < 0.0) err = -err;
      checks++;
      if (err > 0.05) begin
        failures++;
        $display("FAIL R10 x=%0d actual=%0d expected~%0d", x, yp, int'(ideal * 128.0));
      end
      if (x > 0) begin
        apply(-x, "R2 mirror");
        check("R2 symmetry", int'(out_data), yp);
      end
    end

    // Random stream with gaps, checked each cycle
    void'($urandom(32'd20240611));
    last = int'(out_data);
    pend = 0;
    pend_x = 0;
    for (int n = 0; n < 3000; n++) begin
      int v, x;
      @(negedge clk);
      if (pend != 0) begin
        check("R8 valid", int'(out_valid), 1);
        check("R5 random", int'(out_data), model(pend_x));
        last = model(pend_x);
      end else begin
        check("R8 no valid", int'(out_valid), 0);
        check("R8 hold", int'(out_data), last);
      end
      v = (($urandom % 4) != 0) ? 1 : 0;
      if (($urandom % 8) == 0) x = int'($signed(16'($urandom)));
      else x = int'($urandom % 1025) - 512;
      in_valid = v[0];
      in_data  = 16'(x);
      pend = v;
      pend_x = x;
    end
    @(negedge clk);
    in_valid = 1'b0;

    // Asynchronous reset while a result is valid
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 16'd10;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 before reset", int'(out_valid), 1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R9 async clear", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", int'(out_valid), 0);

    finish_run();
  end
endmodule